// File: doc/BRIEF.md
# I2C Receive Acknowledge Control

This block decides, for every byte an I2C receiver takes in, whether the acknowledge slot carries ACK (SDA pulled low) or NACK (SDA released). It does not shift data. It watches single-cycle strobes that mark the SCL rising and falling edges, together with the index of the bit currently on the bus. It merges every reason to refuse a byte into one level, and that level is held for the whole acknowledge clock. These reasons are: a local module reset, a one-shot refusal request from software, a slave with transfers switched off, a slave whose receive holding register is still full, and a master receiver that is finishing its transfer.

For a master receiver the block also asks for a STOP condition. In repeat mode a pending stop request refuses the current byte and raises the STOP request when its acknowledge clock ends. In counted mode a down-counter of remaining bytes is loaded beforehand. The byte that takes the count from one to zero is refused and followed by STOP, provided a stop was requested. If no stop was requested at that point, the STOP is raised as soon as a request does arrive.

Top module: `i2c_rx_ack_ctrl`

## Requirements
- R1: After reset, and whenever no acknowledge slot is open, `sda_lvl_o` is 1 (released) and `ack_slot_o` is 0. If no refusal condition holds when a slot opens, `sda_lvl_o` is 0 (ACK) for that slot.
- R2: A slot opens on the clock after an `scl_fall_i` strobe with `bit_idx_i` = 7, which is the end of the eighth data bit. Bit indices run 0 to 7 for data and 8 for the acknowledge clock. The level is fixed at that point and stays unchanged until the `scl_fall_i` strobe with `bit_idx_i` = 8 closes the slot, and `sda_lvl_o` returns to 1 on the clock after that strobe.
- R3: As a slave (`role_master_i` = 0), a byte is refused when `xfer_en_i` is 0 at the moment the slot opens.
- R4: As a slave, a byte is refused when `rx_full_i` is 1 at the moment the slot opens (overrun).
- R5: While `mod_rst_i` is 1, every byte is refused in either role. A `mod_rst_i` pulse also discards a held refusal request and clears the byte counter.
- R6: A pulse on `nack_req_i` seen on a clock before the `scl_rise_i` strobe with `bit_idx_i` = 7 refuses that byte. The request is then used up, so the following byte is acknowledged.
- R7: A `nack_req_i` pulse seen on or after that rising strobe is held and refuses the next byte instead, and only that byte.
- R8: As a master in repeat mode (`repeat_i` = 1), `stop_req_i` = 1 at slot opening refuses the byte. `stop_gen_o` then pulses on the clock after the strobe that closes the slot.
- R9: As a master in counted mode (`repeat_i` = 0), `cnt_load_i` loads `cnt_val_i`, and each slot opening decrements the count. With `stop_req_i` = 1, the byte that takes the count from 1 to 0 is refused and followed by a `stop_gen_o` pulse at slot close, while earlier bytes are acknowledged.
- R10: In counted mode, if the count reaches zero while `stop_req_i` is 0, that byte is acknowledged and no STOP is raised. A later `stop_req_i` = 1 outside a slot raises `stop_gen_o` on the following clock.
- R11: `stop_gen_o` is never high on two consecutive clocks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| role_master_i | input | 1 | 1 = master receiver, 0 = slave receiver |
| repeat_i | input | 1 | Master: 1 = repeat mode, 0 = counted mode |
| stop_req_i | input | 1 | Request to end the transfer with STOP |
| xfer_en_i | input | 1 | Slave data transfers enabled |
| mod_rst_i | input | 1 | Local module reset, active high |
| rx_full_i | input | 1 | Receive holding register still full |
| nack_req_i | input | 1 | One-shot request to refuse a byte |
| scl_rise_i | input | 1 | Single-cycle strobe at an SCL rising edge |
| scl_fall_i | input | 1 | Single-cycle strobe at an SCL falling edge |
| bit_idx_i | input | 4 | Bit being clocked: 0..7 data, 8 acknowledge |
| cnt_load_i | input | 1 | Load the remaining-byte counter |
| cnt_val_i | input | 8 | Value to load into the counter |
| sda_lvl_o | output | 1 | Level for SDA: 0 = ACK, 1 = NACK or released |
| ack_slot_o | output | 1 | Acknowledge slot open |
| stop_gen_o | output | 1 | One-cycle request to generate STOP |

## Verification
If the held refusal request is lost or moved to the wrong byte, the error first shows as a wrong level on `sda_lvl_o` one clock after the falling strobe that ends bit 7 of the affected byte, or of the byte after it. A counter that is off by one shows as a NACK and a `stop_gen_o` pulse on the wrong byte of a counted burst, and this becomes visible at the close of that byte's slot. A lost deferred-stop flag shows as no pulse on the clock after `stop_req_i` rises once the count is exhausted. Slot timing faults show up within one clock of either falling strobe as a level that moves or is released at the wrong moment.

// File: rtl/i2c_ack_pkg.sv
package i2c_ack_pkg;

   // Individual reasons for refusing a received byte
   typedef struct packed {
      logic hard_rst;
      logic modifier;
      logic slave_off;
      logic overrun;
      logic stop_end;
   } nack_why_t;

   function automatic logic any_nack(input nack_why_t why);
      return |why;
   endfunction

endpackage

// File: rtl/i2c_ack_modreq.sv
// One-shot refusal request: pending until the last-bit rising strobe,
// then armed for exactly one decision.
module i2c_ack_modreq (
   input  logic clk,
   input  logic rst_n,
   input  logic clr,
   input  logic req,
   input  logic capture,
   input  logic consume,
   output logic armed
);
   logic pend_q;
   logic armed_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pend_q  <= 1'b0;
         armed_q <= 1'b0;
      end else if (clr) begin
         pend_q  <= 1'b0;
         armed_q <= 1'b0;
      end else begin
         // A request on the capture edge itself stays pending for the next byte
         pend_q <= (capture ? 1'b0 : pend_q) | req;
         if (capture)
            armed_q <= pend_q;
         else if (consume)
            armed_q <= 1'b0;
      end
   end

   assign armed = armed_q;
endmodule

// File: rtl/i2c_ack_bytecnt.sv
// Remaining-byte down-counter for counted master reception.
module i2c_ack_bytecnt #(
   parameter int CNT_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr,
   input  logic             load,
   input  logic [CNT_W-1:0] load_val,
   input  logic             dec,
   output logic             is_one
);
   localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

   logic [CNT_W-1:0] cnt_q;

   generate
      if (CNT_W < 1) begin : g_bad_w
         $error("i2c_ack_bytecnt: CNT_W must be at least 1");
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         cnt_q <= '0;
      else if (clr)
         cnt_q <= '0;
      else if (load)
         cnt_q <= load_val;
      else if (dec && (cnt_q != '0))
         cnt_q <= cnt_q - ONE;
   end

   assign is_one = (cnt_q == ONE);
endmodule

// File: rtl/i2c_ack_slot.sv
// Holds the acknowledge level across the acknowledge clock and schedules STOP.
module i2c_ack_slot (
   input  logic clk,
   input  logic rst_n,
   input  logic clr,
   input  logic open_slot,
   input  logic close_slot,
   input  logic nack,
   input  logic stop_at_end,
   input  logic idle_set,
   input  logic idle_clr,
   input  logic stop_req,
   output logic sda_lvl,
   output logic slot,
   output logic stop_gen
);
   logic lvl_q, slot_q, pend_q, idle_q, stop_q;
   logic fire_idle;

   assign fire_idle = idle_q && stop_req && !slot_q && !clr;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         lvl_q  <= 1'b1;
         slot_q <= 1'b0;
      end else if (open_slot) begin
         lvl_q  <= nack;
         slot_q <= 1'b1;
      end else if (close_slot) begin
         lvl_q  <= 1'b1;
         slot_q <= 1'b0;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pend_q <= 1'b0;
         idle_q <= 1'b0;
         stop_q <= 1'b0;
      end else begin
         stop_q <= (close_slot && pend_q && !clr) || fire_idle;
         if (clr || close_slot)
            pend_q <= 1'b0;
         else if (open_slot)
            pend_q <= stop_at_end;
         if (clr || idle_clr || fire_idle)
            idle_q <= 1'b0;
         else if (open_slot)
            idle_q <= idle_set;
      end
   end

   assign sda_lvl  = lvl_q;
   assign slot     = slot_q;
   assign stop_gen = stop_q;
endmodule

// File: rtl/i2c_rx_ack_ctrl.sv
module i2c_rx_ack_ctrl #(
   parameter int DATA_BITS = 8,
   parameter int BIT_W     = 4,
   parameter int CNT_W     = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             role_master_i,
   input  logic             repeat_i,
   input  logic             stop_req_i,
   input  logic             xfer_en_i,
   input  logic             mod_rst_i,
   input  logic             rx_full_i,
   input  logic             nack_req_i,
   input  logic             scl_rise_i,
   input  logic             scl_fall_i,
   input  logic [BIT_W-1:0] bit_idx_i,
   input  logic             cnt_load_i,
   input  logic [CNT_W-1:0] cnt_val_i,
   output logic             sda_lvl_o,
   output logic             ack_slot_o,
   output logic             stop_gen_o
);
   import i2c_ack_pkg::*;

   localparam logic [BIT_W-1:0] LAST_IDX = BIT_W'(DATA_BITS - 1);
   localparam logic [BIT_W-1:0] ACK_IDX  = BIT_W'(DATA_BITS);

   generate
      if ((1 << BIT_W) <= DATA_BITS) begin : g_bad_bitw
         $error("i2c_rx_ack_ctrl: BIT_W too narrow for DATA_BITS");
      end
      if (DATA_BITS < 1) begin : g_bad_bits
         $error("i2c_rx_ack_ctrl: DATA_BITS must be positive");
      end
   endgenerate

   logic      capture, decide, close_slot;
   logic      armed, cnt_is_one, counted, slot;
   nack_why_t why;

   assign capture    = scl_rise_i && (bit_idx_i == LAST_IDX);
   assign decide     = scl_fall_i && (bit_idx_i == LAST_IDX);
   assign close_slot = scl_fall_i && (bit_idx_i == ACK_IDX) && slot;
   assign counted    = role_master_i && !repeat_i;

   always_comb begin
      why.hard_rst  = mod_rst_i;
      why.modifier  = armed;
      why.slave_off = !role_master_i && !xfer_en_i;
      why.overrun   = !role_master_i && rx_full_i;
      why.stop_end  = role_master_i && stop_req_i && (repeat_i || cnt_is_one);
   end

   i2c_ack_modreq u_modreq (
      .clk     (clk),
      .rst_n   (rst_n),
      .clr     (mod_rst_i),
      .req     (nack_req_i),
      .capture (capture),
      .consume (decide),
      .armed   (armed)
   );

   i2c_ack_bytecnt #(.CNT_W(CNT_W)) u_bytecnt (
      .clk      (clk),
      .rst_n    (rst_n),
      .clr      (mod_rst_i),
      .load     (cnt_load_i),
      .load_val (cnt_val_i),
      .dec      (decide && counted),
      .is_one   (cnt_is_one)
   );

   i2c_ack_slot u_slot (
      .clk         (clk),
      .rst_n       (rst_n),
      .clr         (mod_rst_i),
      .open_slot   (decide),
      .close_slot  (close_slot),
      .nack        (any_nack(why)),
      .stop_at_end (why.stop_end && !mod_rst_i),
      .idle_set    (counted && !stop_req_i && cnt_is_one && !mod_rst_i),
      .idle_clr    (cnt_load_i),
      .stop_req    (stop_req_i && counted),
      .sda_lvl     (sda_lvl_o),
      .slot        (slot),
      .stop_gen    (stop_gen_o)
   );

   assign ack_slot_o = slot;
endmodule

// File: rtl/i2c_rx_ack_chk.sv
module i2c_rx_ack_chk (
   input logic clk,
   input logic rst_n,
   input logic role_master_i,
   input logic xfer_en_i,
   input logic mod_rst_i,
   input logic rx_full_i,
   input logic sda_lvl_o,
   input logic ack_slot_o,
   input logic stop_gen_o
);
   AST_RELEASED_OUTSIDE: assert property (@(posedge clk) disable iff (!rst_n)
      !ack_slot_o |-> sda_lvl_o); // R1
   AST_SLOT_LEVEL_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      (ack_slot_o && $past(ack_slot_o)) |-> $stable(sda_lvl_o)); // R2
   AST_SLAVE_DISABLED: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(ack_slot_o) && $past(!role_master_i && !xfer_en_i)) |-> sda_lvl_o); // R3
   AST_SLAVE_OVERRUN: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(ack_slot_o) && $past(!role_master_i && rx_full_i)) |-> sda_lvl_o); // R4
   AST_RESET_REFUSES: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(ack_slot_o) && $past(mod_rst_i)) |-> sda_lvl_o); // R5
   AST_STOP_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      stop_gen_o |=> !stop_gen_o); // R11
endmodule

bind i2c_rx_ack_ctrl i2c_rx_ack_chk chk_i (
   .clk           (clk),
   .rst_n         (rst_n),
   .role_master_i (role_master_i),
   .xfer_en_i     (xfer_en_i),
   .mod_rst_i     (mod_rst_i),
   .rx_full_i     (rx_full_i),
   .sda_lvl_o     (sda_lvl_o),
   .ack_slot_o    (ack_slot_o),
   .stop_gen_o    (stop_gen_o)
);

// File: tb/i2c_rx_ack_ctrl_tb_top.sv
module i2c_rx_ack_ctrl_tb_top;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       role_master = 1'b0, repeat_m = 1'b0, stop_req = 1'b0;
   logic       xfer_en = 1'b1, mod_rst = 1'b0, rx_full = 1'b0, nack_req = 1'b0;
   logic       scl_rise = 1'b0, scl_fall = 1'b0, cnt_load = 1'b0;
   logic [3:0] bit_idx = '0;
   logic [7:0] cnt_val = '0;
   logic       sda_lvl, ack_slot, stop_gen;

   int n_chk = 0;
   int n_bad = 0;
   int cyc = 0;

   always #4 clk = ~clk;

   i2c_rx_ack_ctrl dut_i (
      .clk(clk), .rst_n(rst_n), .role_master_i(role_master), .repeat_i(repeat_m),
      .stop_req_i(stop_req), .xfer_en_i(xfer_en), .mod_rst_i(mod_rst),
      .rx_full_i(rx_full), .nack_req_i(nack_req), .scl_rise_i(scl_rise),
      .scl_fall_i(scl_fall), .bit_idx_i(bit_idx), .cnt_load_i(cnt_load),
      .cnt_val_i(cnt_val), .sda_lvl_o(sda_lvl), .ack_slot_o(ack_slot),
      .stop_gen_o(stop_gen)
   );

   always @(posedge clk) begin
      cyc <= cyc + 1;
      if (cyc == 100000) begin
         n_bad = n_bad + 1;
         $display("FAIL watchdog: run did not finish (actual hung, expected done)");
         $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
         $finish;
      end
   end

   task automatic chk(input string req, input logic act, input logic exp);
      n_chk = n_chk + 1;
      if (act !== exp) begin
         n_bad = n_bad + 1;
         $display("FAIL %s: actual %b expected %b", req, act, exp);
      end
   endtask

   // One byte on the bus; early/late place a refusal request around bit 7's rise
   logic r_open, r_slot_open, r_end, r_slot_after, r_stop_after, r_stop_next;
   task automatic run_byte(input bit early, input bit late);
      for (int b = 0; b <= 8; b++) begin
         bit_idx = 4'(b);
         if (b == 7 && early) begin
            nack_req = 1'b1; @(negedge clk); nack_req = 1'b0;
         end
         scl_rise = 1'b1; @(negedge clk); scl_rise = 1'b0;
         if (b == 7 && late) begin
            nack_req = 1'b1; @(negedge clk); nack_req = 1'b0;
         end
         @(negedge clk); @(negedge clk);
         if (b == 8) r_end = sda_lvl;
         scl_fall = 1'b1; @(negedge clk); scl_fall = 1'b0;
         if (b == 7) begin r_open = sda_lvl; r_slot_open = ack_slot; end
         if (b == 8) begin r_slot_after = ack_slot; r_stop_after = stop_gen; end
      end
      bit_idx = '0;
      @(negedge clk);
      r_stop_next = stop_gen;
   endtask

   task automatic pulse_mod_rst();
      mod_rst = 1'b1; @(negedge clk); mod_rst = 1'b0; @(negedge clk);
   endtask

   task automatic load_cnt(input logic [7:0] v);
      cnt_val = v; cnt_load = 1'b1; @(negedge clk); cnt_load = 1'b0;
   endtask

   task automatic t_reset();
      chk("R1 reset level", sda_lvl, 1'b1);
      chk("R1 reset slot", ack_slot, 1'b0);
      chk("R11 reset stop", stop_gen, 1'b0);
   endtask

   task automatic t_slave_default();
      role_master = 0; xfer_en = 1; rx_full = 0;
      run_byte(0, 0);
      chk("R2 slot opens", r_slot_open, 1'b1);
      chk("R1 ack level", r_open, 1'b0);
      chk("R2 held to end", r_end, 1'b0);
      chk("R2 slot closed", r_slot_after, 1'b0);
   endtask

   task automatic t_slave_off();
      xfer_en = 0; run_byte(0, 0); xfer_en = 1;
      chk("R3 disabled nack", r_open, 1'b1);
      chk("R3 held", r_end, 1'b1);
   endtask

   task automatic t_overrun();
      rx_full = 1; run_byte(0, 0); rx_full = 0;
      chk("R4 overrun nack", r_open, 1'b1);
      run_byte(0, 0);
      chk("R4 cleared ack", r_open, 1'b0);
   endtask

   task automatic t_mod_early();
      run_byte(1, 0);
      chk("R6 early nack", r_open, 1'b1);
      run_byte(0, 0);
      chk("R6 used up", r_open, 1'b0);
   endtask

   task automatic t_mod_late();
      run_byte(0, 1);
      chk("R7 late ack now", r_open, 1'b0);
      run_byte(0, 0);
      chk("R7 next nack", r_open, 1'b1);
      run_byte(0, 0);
      chk("R7 only once", r_open, 1'b0);
   endtask

   task automatic t_mod_rst();
      role_master = 1; repeat_m = 1;
      mod_rst = 1; run_byte(0, 0); mod_rst = 0;
      chk("R5 master reset nack", r_open, 1'b1);
      role_master = 0;
      run_byte(0, 1);
      pulse_mod_rst();
      run_byte(0, 0);
      chk("R5 request discarded", r_open, 1'b0);
   endtask

   task automatic t_repeat_stop();
      role_master = 1; repeat_m = 1; stop_req = 0;
      run_byte(0, 0);
      chk("R8 no stop ack", r_open, 1'b0);
      chk("R8 no stop pulse", r_stop_after, 1'b0);
      stop_req = 1; run_byte(0, 0); stop_req = 0;
      chk("R8 stop nack", r_open, 1'b1);
      chk("R8 stop pulse", r_stop_after, 1'b1);
      chk("R11 stop one cycle", r_stop_next, 1'b0);
   endtask

   task automatic t_counted_stop();
      role_master = 1; repeat_m = 0; stop_req = 1;
      load_cnt(8'd3);
      run_byte(0, 0);
      chk("R9 byte1 ack", r_open, 1'b0);
      chk("R9 byte1 no stop", r_stop_after, 1'b0);
      run_byte(0, 0);
      chk("R9 byte2 ack", r_open, 1'b0);
      run_byte(0, 0);
      chk("R9 last nack", r_open, 1'b1);
      chk("R9 last stop", r_stop_after, 1'b1);
      chk("R11 single", r_stop_next, 1'b0);
      stop_req = 0;
   endtask

   task automatic t_counted_late_stop();
      role_master = 1; repeat_m = 0; stop_req = 0;
      load_cnt(8'd2);
      run_byte(0, 0);
      run_byte(0, 0);
      chk("R10 zero ack", r_open, 1'b0);
      chk("R10 no stop yet", r_stop_after, 1'b0);
      chk("R10 still none", stop_gen, 1'b0);
      stop_req = 1; @(negedge clk);
      chk("R10 late stop", stop_gen, 1'b1);
      @(negedge clk);
      chk("R11 late single", stop_gen, 1'b0);
      stop_req = 0;
   endtask

   task automatic t_cnt_clear();
      role_master = 1; repeat_m = 0; stop_req = 1;
      load_cnt(8'd2);
      run_byte(0, 0);
      stop_req = 0; pulse_mod_rst(); stop_req = 1;
      run_byte(0, 0);
      chk("R5 counter cleared ack", r_open, 1'b0);
      chk("R5 counter cleared no stop", r_stop_after, 1'b0);
      stop_req = 0;
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_slave_default();
      t_slave_off();
      t_overrun();
      t_mod_early();
      t_mod_late();
      t_mod_rst();
      t_repeat_stop();
      t_counted_stop();
      t_counted_late_stop();
      t_cnt_clear();
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end
endmodule